// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a serial shift engine and a processor bus and holds the byte queues for both directions: a small receive queue filled by the shift engine and emptied by bus reads, and a small transmit queue filled by bus writes and emptied by the shift engine. It reports both fill levels in a 16-bit status word. It flags a byte lost to a full receive queue and a transfer started with nothing to send.

An interrupt is raised when a programmed byte count is reached. In receive-driven mode (mode bit 0) the count is the receive fill level. In transmit-driven mode (mode bit 1) the count is a running number of bytes handed to the shift engine. The two error flags also raise the interrupt unless the flush bit for their direction is set. All event flags and the interrupt line stay set until software reads the status word. A read that coincides with a new event never loses that event.

Top module: `spi_fifo_stat`

## Requirements
- R1: Each queue holds up to 4 bytes in first-in first-out order. The receive level is shown in status bits 10:8 and the transmit level in bits 3:1, as a binary count from 0 (empty) to 4.
- R2: Status bits 15:12 always read zero. After reset the whole status word is zero and the interrupt output is low.
- R3: Status bit 11 is 1 exactly while the receive level is greater than the threshold, and 0 when it is equal or lower.
- R4: A received byte that arrives while the receive queue holds 4 bytes, with no bus read in the same cycle, is discarded. The stored bytes are kept, and status bit 7 (overrun) sets.
- R5: A send strobe while the transmit queue is empty sets status bit 4 (underrun) and removes nothing.
- R6: In mode 0, status bit 6 sets when an accepted received byte leaves the receive level equal to a non-zero threshold. It never sets in mode 1 or with threshold 0.
- R7: In mode 1, an internal count of accepted send strobes sets status bit 5 each time it reaches a non-zero threshold, and then restarts at zero. In mode 0 the count holds and bit 5 does not set.
- R8: Status bit 0 and the irq output set on an R6 or R7 event, on overrun unless the receive flush bit is 1, and on underrun unless the transmit flush bit is 1.
- R9: A status read clears bits 7, 6, 5, 4 and 0 and the irq output. It leaves the levels and bit 11 unchanged.
- R10: When a flag-setting event occurs in the same cycle as a status read, the flag ends the cycle set.
- R11: A bus write while the transmit queue holds 4 bytes is discarded, and the stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_strobe_i | input | 1 | Shift engine has a received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_pull_i | input | 1 | Shift engine takes a byte / starts a transfer |
| tx_byte_o | output | 8 | Transmit queue head byte |
| tx_avail_o | output | 1 | Transmit queue not empty |
| bus_wr_tx_i | input | 1 | Bus write to transmit data |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rd_rx_i | input | 1 | Bus read of receive data (pops the head) |
| bus_rx_data_o | output | 8 | Receive queue head byte |
| bus_rd_stat_i | input | 1 | Bus read of the status word |
| stat_word_o | output | 16 | Status word |
| cfg_count_i | input | 3 | Byte-count threshold |
| cfg_txmode_i | input | 1 | 0: receive-driven, 1: transmit-driven interrupt |
| cfg_rx_flush_i | input | 1 | Inhibits the overrun interrupt |
| cfg_tx_flush_i | input | 1 | Inhibits the underrun interrupt |
| irq_o | output | 1 | Interrupt line |

## Verification
The receive path is filled one byte at a time past the threshold and then past capacity. This separates the level-equals-threshold interrupt from the strict greater-than excess bit, and a dropped overrun byte from a stored one. The transmit path is drained past empty in both modes, which shows that the send count runs only in mode 1 and wraps at the threshold, and that an empty pull is counted as underrun and not as a send. Each error condition is repeated with its flush bit set, so the flag can be seen apart from the interrupt. Coincident status read and push, threshold zero and writes into a full transmit queue cover the remaining corners.

// File: rtl/spi_fifo_stat_pkg.sv
// Package: shared widths and status-word bit positions for the SPI FIFO
// status unit. The bit positions are software-visible and fixed.
package spi_fifo_stat_pkg;
    localparam int STAT_W     = 16;
    localparam int B_RX_EXC   = 11;
    localparam int B_RX_LVL_H = 10;
    localparam int B_RX_LVL_L = 8;
    localparam int B_RX_OVR   = 7;
    localparam int B_RX_IRQ   = 6;
    localparam int B_TX_IRQ   = 5;
    localparam int B_TX_UNR   = 4;
    localparam int B_TX_LVL_H = 3;
    localparam int B_TX_LVL_L = 1;
    localparam int B_SUM      = 0;

    // Sticky event flags held by the flag unit.
    typedef struct packed {
        logic ovr;
        logic rx_irq;
        logic tx_irq;
        logic unr;
        logic sum;
    } flags_t;
endpackage

// File: rtl/spi_byte_fifo.sv
// Module: spi_byte_fifo
// Small circular byte queue. A push is accepted when there is room, or when
// a pop happens in the same cycle. A pop is accepted when not empty. It reports
// rejected pushes and pops and the level after this cycle's update.
// Assumes DEPTH >= 2. The head byte is combinational from storage.
module spi_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    level_o,
    output logic [CW-1:0]    level_nxt_o,
    output logic             push_ok_o,
    output logic             pop_ok_o,
    output logic             push_drop_o,
    output logic             pop_empty_o
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             full, empty;
    logic [AW-1:0]    wr_ptr_inc, rd_ptr_inc;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Pointer increment: plain wrap for power-of-two depth, compare otherwise.
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_ptr_inc = wr_ptr + 1'b1;
            assign rd_ptr_inc = rd_ptr + 1'b1;
        end else begin : g_mod
            assign wr_ptr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Accept/reject decisions for this cycle.
    always_comb begin
        pop_ok_o    = pop_i && !empty;
        pop_empty_o = pop_i && empty;
        push_ok_o   = push_i && (!full || pop_ok_o);
        push_drop_o = push_i && !push_ok_o;
    end

    // Level after this cycle's accepted push and pop.
    always_comb begin
        level_nxt_o = count;
        if (push_ok_o && !pop_ok_o) level_nxt_o = count + 1'b1;
        if (!push_ok_o && pop_ok_o) level_nxt_o = count - 1'b1;
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok_o) wr_ptr <= wr_ptr_inc;
            if (pop_ok_o)  rd_ptr <= rd_ptr_inc;
            count <= level_nxt_o;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok_o) mem[wr_ptr] <= data_i;
    end

    assign head_o  = mem[rd_ptr];
    assign level_o = count;

    // R1: the level never exceeds the depth.
    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4/R11: a push into a full queue without a pop leaves the level unchanged.
    a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi_stat_flags.sv
// Module: spi_stat_flags
// Sticky event flags, summary interrupt and transmit send counter.
// Event inputs come from the two queues in the same cycle they happen.
// A status read clears the flags, but an event in the same cycle wins.
module spi_stat_flags #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_push_ok_i,
    input  logic [CW-1:0] rx_level_nxt_i,
    input  logic          rx_drop_i,
    input  logic          tx_pop_ok_i,
    input  logic          tx_pop_empty_i,
    input  logic [CW-1:0] cfg_count_i,
    input  logic          cfg_txmode_i,
    input  logic          cfg_rx_flush_i,
    input  logic          cfg_tx_flush_i,
    input  logic          rd_stat_i,
    output spi_fifo_stat_pkg::flags_t flags_o
);
    import spi_fifo_stat_pkg::*;

    flags_t        fl_q;
    logic [CW-1:0] sent_cnt;
    logic          rx_irq_evt, tx_irq_evt, ovr_evt, unr_evt, sum_evt;
    logic          thr_nz, sent_hit;

    assign thr_nz = (cfg_count_i != '0);

    // Receive interrupt event: accepted byte brings the level to the threshold.
    always_comb begin
        rx_irq_evt = !cfg_txmode_i && thr_nz && rx_push_ok_i
                     && (rx_level_nxt_i == cfg_count_i);
    end

    // Send counter reaches the threshold on this accepted pull.
    always_comb begin
        sent_hit   = thr_nz && ((sent_cnt + 1'b1) == cfg_count_i);
        tx_irq_evt = cfg_txmode_i && tx_pop_ok_i && sent_hit;
    end

    // Error events and the combined interrupt event.
    always_comb begin
        ovr_evt = rx_drop_i;
        unr_evt = tx_pop_empty_i;
        sum_evt = rx_irq_evt || tx_irq_evt
                  || (ovr_evt && !cfg_rx_flush_i)
                  || (unr_evt && !cfg_tx_flush_i);
    end

    // Send counter: runs in transmit mode only, restarts at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_cnt <= '0;
        end else if (cfg_txmode_i && tx_pop_ok_i) begin
            sent_cnt <= sent_hit ? '0 : sent_cnt + 1'b1;
        end
    end

    // Sticky flags: set by events, cleared by a status read, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q.ovr    <= ovr_evt    || (fl_q.ovr    && !rd_stat_i);
            fl_q.rx_irq <= rx_irq_evt || (fl_q.rx_irq && !rd_stat_i);
            fl_q.tx_irq <= tx_irq_evt || (fl_q.tx_irq && !rd_stat_i);
            fl_q.unr    <= unr_evt    || (fl_q.unr    && !rd_stat_i);
            fl_q.sum    <= sum_evt    || (fl_q.sum    && !rd_stat_i);
        end
    end

    assign flags_o = fl_q;

    // R10: an overrun event is visible after the edge even with a read.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> fl_q.ovr);

    // R9: a read with no events clears the summary bit.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_i && !rx_irq_evt && !tx_irq_evt && !ovr_evt && !unr_evt)
        |=> !fl_q.sum);

    // R7: the transmit interrupt flag only rises in transmit mode.
    a_r7_txirq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.tx_irq) |-> $past(cfg_txmode_i));

    // R8: a flushed overrun alone does not raise the summary bit.
    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && cfg_rx_flush_i && !rx_irq_evt && !tx_irq_evt && !unr_evt
         && !fl_q.sum) |=> !fl_q.sum);
endmodule

// File: rtl/spi_fifo_stat.sv
// Module: spi_fifo_stat (top)
// Receive and transmit byte queues with a status word and an interrupt.
// The shift engine drives rx_strobe_i and tx_pull_i. The bus side drives
// single-cycle write, read and status-read strobes. Assumes a 4-entry depth
// so that both levels fit the 3-bit status fields.
module spi_fifo_stat #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_strobe_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          tx_pull_i,
    output logic [DW-1:0] tx_byte_o,
    output logic          tx_avail_o,
    input  logic          bus_wr_tx_i,
    input  logic [DW-1:0] bus_wdata_i,
    input  logic          bus_rd_rx_i,
    output logic [DW-1:0] bus_rx_data_o,
    input  logic          bus_rd_stat_i,
    output logic [15:0]   stat_word_o,
    input  logic [CW-1:0] cfg_count_i,
    input  logic          cfg_txmode_i,
    input  logic          cfg_rx_flush_i,
    input  logic          cfg_tx_flush_i,
    output logic          irq_o
);
    import spi_fifo_stat_pkg::*;

    logic [CW-1:0] rx_lvl, rx_lvl_nxt, tx_lvl, tx_lvl_nxt;
    logic          rx_push_ok, rx_pop_ok, rx_drop, rx_pop_empty;
    logic          tx_push_ok, tx_pop_ok, tx_drop, tx_pop_empty;
    flags_t        flags;

    spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(rx_strobe_i), .data_i(rx_byte_i), .pop_i(bus_rd_rx_i),
        .head_o(bus_rx_data_o), .level_o(rx_lvl), .level_nxt_o(rx_lvl_nxt),
        .push_ok_o(rx_push_ok), .pop_ok_o(rx_pop_ok),
        .push_drop_o(rx_drop), .pop_empty_o(rx_pop_empty)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(bus_wr_tx_i), .data_i(bus_wdata_i), .pop_i(tx_pull_i),
        .head_o(tx_byte_o), .level_o(tx_lvl), .level_nxt_o(tx_lvl_nxt),
        .push_ok_o(tx_push_ok), .pop_ok_o(tx_pop_ok),
        .push_drop_o(tx_drop), .pop_empty_o(tx_pop_empty)
    );

    spi_stat_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .rx_push_ok_i(rx_push_ok), .rx_level_nxt_i(rx_lvl_nxt),
        .rx_drop_i(rx_drop),
        .tx_pop_ok_i(tx_pop_ok), .tx_pop_empty_i(tx_pop_empty),
        .cfg_count_i(cfg_count_i), .cfg_txmode_i(cfg_txmode_i),
        .cfg_rx_flush_i(cfg_rx_flush_i), .cfg_tx_flush_i(cfg_tx_flush_i),
        .rd_stat_i(bus_rd_stat_i), .flags_o(flags)
    );

    assign tx_avail_o = (tx_lvl != '0);
    assign irq_o      = flags.sum;

    // Status word assembly from levels, excess compare and sticky flags.
    always_comb begin
        stat_word_o                         = '0;
        stat_word_o[B_RX_EXC]               = (rx_lvl > cfg_count_i);
        stat_word_o[B_RX_LVL_H:B_RX_LVL_L]  = 3'(rx_lvl);
        stat_word_o[B_RX_OVR]               = flags.ovr;
        stat_word_o[B_RX_IRQ]               = flags.rx_irq;
        stat_word_o[B_TX_IRQ]               = flags.tx_irq;
        stat_word_o[B_TX_UNR]               = flags.unr;
        stat_word_o[B_TX_LVL_H:B_TX_LVL_L]  = 3'(tx_lvl);
        stat_word_o[B_SUM]                  = flags.sum;
    end

    // R2: reserved status bits never read as one.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word_o[15:12] == 4'b0000);

    // R5: an empty pull leaves the transmit level at zero.
    a_r5_empty_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pull_i && tx_lvl == '0 && !bus_wr_tx_i) |=> (tx_lvl == '0));
endmodule

// File: tb/tb_spi_fifo_stat.sv
// Directed bench for spi_fifo_stat: one task per scenario.
module tb_spi_fifo_stat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_strobe_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        tx_pull_i = 1'b0;
    logic [7:0]  tx_byte_o;
    logic        tx_avail_o;
    logic        bus_wr_tx_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic        bus_rd_rx_i = 1'b0;
    logic [7:0]  bus_rx_data_o;
    logic        bus_rd_stat_i = 1'b0;
    logic [15:0] stat_word_o;
    logic [2:0]  cfg_count_i = 3'd2;
    logic        cfg_txmode_i = 1'b0;
    logic        cfg_rx_flush_i = 1'b0;
    logic        cfg_tx_flush_i = 1'b0;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_fifo_stat dut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk); rx_strobe_i = 1'b1; rx_byte_i = b;
        @(negedge clk); rx_strobe_i = 1'b0;
    endtask
    task automatic rd_stat();
        @(negedge clk); bus_rd_stat_i = 1'b1;
        @(negedge clk); bus_rd_stat_i = 1'b0;
    endtask
    task automatic rd_rx(input logic [7:0] exp, input string req);
        chk(req, {8'h00, bus_rx_data_o}, {8'h00, exp});
        @(negedge clk); bus_rd_rx_i = 1'b1;
        @(negedge clk); bus_rd_rx_i = 1'b0;
    endtask
    task automatic wr_tx(input logic [7:0] b);
        @(negedge clk); bus_wr_tx_i = 1'b1; bus_wdata_i = b;
        @(negedge clk); bus_wr_tx_i = 1'b0;
    endtask
    task automatic pull_tx();
        @(negedge clk); tx_pull_i = 1'b1;
        @(negedge clk); tx_pull_i = 1'b0;
    endtask

    // R2: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset word", stat_word_o, 16'h0000);
        chk("R2 reset irq", {15'd0, irq_o}, 16'd1 & 16'd0);
    endtask

    // R1 R3 R4 R6 R8 R9: receive fill, overrun, flush, drain.
    task automatic t_rx_path();
        cfg_count_i = 3'd2; cfg_txmode_i = 1'b0;
        push_rx(8'hA1);
        chk("R1 rx level 1", {13'd0, stat_word_o[10:8]}, 16'd1);
        chk("R6 no irq below thr", {15'd0, stat_word_o[6]}, 16'd0);
        push_rx(8'hB2);
        chk("R6 rx irq at thr", {15'd0, stat_word_o[6]}, 16'd1);
        chk("R8 irq on rx event", {15'd0, irq_o}, 16'd1);
        chk("R3 excess low at equal", {15'd0, stat_word_o[11]}, 16'd0);
        push_rx(8'hC3);
        chk("R3 excess high above", {15'd0, stat_word_o[11]}, 16'd1);
        rd_stat();
        chk("R9 read clears flags", stat_word_o & 16'h00F1, 16'h0000);
        chk("R9 level kept", {13'd0, stat_word_o[10:8]}, 16'd3);
        chk("R9 excess kept", {15'd0, stat_word_o[11]}, 16'd1);
        chk("R9 irq low", {15'd0, irq_o}, 16'd0);
        push_rx(8'hD4);
        chk("R6 no irq past thr", {15'd0, stat_word_o[6]}, 16'd0);
        push_rx(8'hE5);
        chk("R4 overrun flag", {15'd0, stat_word_o[7]}, 16'd1);
        chk("R4 level stays 4", {13'd0, stat_word_o[10:8]}, 16'd4);
        chk("R8 overrun irq", {15'd0, irq_o}, 16'd1);
        rd_stat();
        cfg_rx_flush_i = 1'b1;
        push_rx(8'hF6);
        chk("R8 flushed overrun flag", {15'd0, stat_word_o[7]}, 16'd1);
        chk("R8 flushed overrun no irq", {15'd0, irq_o}, 16'd0);
        chk("R8 flushed overrun no sum", {15'd0, stat_word_o[0]}, 16'd0);
        rd_stat();
        cfg_rx_flush_i = 1'b0;
        rd_rx(8'hA1, "R1 rx order 1");
        rd_rx(8'hB2, "R4 rx order 2");
        rd_rx(8'hC3, "R4 rx order 3");
        rd_rx(8'hD4, "R4 rx order 4");
        chk("R1 rx empty", {13'd0, stat_word_o[10:8]}, 16'd0);
    endtask

    // R5 R7 R8: transmit mode count, underrun, flush.
    task automatic t_tx_path();
        cfg_count_i = 3'd2; cfg_txmode_i = 1'b1;
        wr_tx(8'h11); wr_tx(8'h22); wr_tx(8'h33);
        chk("R1 tx level 3", {13'd0, stat_word_o[3:1]}, 16'd3);
        chk("R1 tx head", {8'h00, tx_byte_o}, 16'h0011);
        pull_tx();
        chk("R7 no irq after 1", {15'd0, stat_word_o[5]}, 16'd0);
        chk("R1 tx head 2", {8'h00, tx_byte_o}, 16'h0022);
        pull_tx();
        chk("R7 tx irq after 2", {15'd0, stat_word_o[5]}, 16'd1);
        chk("R8 irq on tx event", {15'd0, irq_o}, 16'd1);
        rd_stat();
        pull_tx();
        chk("R7 counter restarted", {15'd0, stat_word_o[5]}, 16'd0);
        chk("R1 tx empty", {13'd0, stat_word_o[3:1]}, 16'd0);
        pull_tx();
        chk("R5 underrun flag", {15'd0, stat_word_o[4]}, 16'd1);
        chk("R5 level stays 0", {13'd0, stat_word_o[3:1]}, 16'd0);
        chk("R8 underrun irq", {15'd0, irq_o}, 16'd1);
        chk("R7 empty pull not counted", {15'd0, stat_word_o[5]}, 16'd0);
        rd_stat();
        cfg_tx_flush_i = 1'b1;
        pull_tx();
        chk("R8 flushed underrun flag", {15'd0, stat_word_o[4]}, 16'd1);
        chk("R8 flushed underrun no irq", {15'd0, irq_o}, 16'd0);
        rd_stat();
        cfg_tx_flush_i = 1'b0;
        // Send count is 1 here; one more accepted pull reaches 2.
        wr_tx(8'h77);
        pull_tx();
        chk("R7 second period irq", {15'd0, stat_word_o[5]}, 16'd1);
        rd_stat();
    endtask

    // R11 R7: full transmit queue drops writes; mode 0 freezes the count.
    task automatic t_tx_full();
        cfg_txmode_i = 1'b0; cfg_count_i = 3'd1;
        for (int i = 0; i < 5; i++) wr_tx(8'h40 + 8'(i));
        chk("R11 tx level 4", {13'd0, stat_word_o[3:1]}, 16'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R11 tx order", {8'h00, tx_byte_o}, {8'h00, 8'h40 + 8'(i)});
            pull_tx();
        end
        chk("R7 no tx irq in mode 0", {15'd0, stat_word_o[5]}, 16'd0);
        chk("R11 tx drained", {13'd0, stat_word_o[3:1]}, 16'd0);
    endtask

    // R6 R10: mode 1 blocks rx irq, read and event coincide, threshold 0.
    task automatic t_corners();
        cfg_txmode_i = 1'b1; cfg_count_i = 3'd1;
        push_rx(8'h55);
        chk("R6 no rx irq in mode 1", {15'd0, stat_word_o[6]}, 16'd0);
        rd_rx(8'h55, "R1 rx single");
        cfg_txmode_i = 1'b0;
        @(negedge clk); rx_strobe_i = 1'b1; rx_byte_i = 8'h66; bus_rd_stat_i = 1'b1;
        @(negedge clk); rx_strobe_i = 1'b0; bus_rd_stat_i = 1'b0;
        chk("R10 set wins flag", {15'd0, stat_word_o[6]}, 16'd1);
        chk("R10 set wins irq", {15'd0, irq_o}, 16'd1);
        rd_stat();
        rd_rx(8'h66, "R10 byte kept");
        cfg_count_i = 3'd0;
        push_rx(8'h99);
        chk("R6 thr 0 no irq", {15'd0, stat_word_o[6]}, 16'd0);
        chk("R3 excess thr 0", {15'd0, stat_word_o[11]}, 16'd1);
        chk("R2 reserved zero", {12'd0, stat_word_o[15:12]}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_rx_path();
        t_tx_path();
        t_tx_full();
        t_corners();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule